// File: doc/BRIEF.md
# Response Packet Validator

This block sits behind a two-wire peripheral-bus receiver and judges each response packet the receiver hands over. The receiver delivers the packet as a run of 32-bit words (the frame word first, then the payload words). When the packet ends it pulses a done strobe together with the number of bits it sampled and the trailing checksum byte. The validator folds every byte of every word into an XOR checksum as the words arrive, counts the words, and keeps the frame word.

One cycle after the done strobe the validator presents a verdict, registered and held until the next packet ends. The verdict carries the decoded frame fields (command, recipient, sender, payload word count) and the sender address with its two player bits dropped. It also carries the five-bit map of attached sub-devices, three error flags and an overall pass flag. A caller can use the flags to decide whether to ask the device for a resend. After every done strobe the running state is cleared, so each packet is judged on its own words alone.

Frame word layout, bit 0 first: bits [7:0] payload word count, bits [15:8] sender address, bits [23:16] recipient address, bits [31:24] command.

Top module: `resp_pkt_validator`

## Requirements
- R1: `out_vld` is high for exactly one cycle, in the cycle after `in_done` is sampled high. At that point `out_cmd` = frame bits [31:24], `out_rcp` = frame bits [23:16] and `out_len` = frame bits [7:0], where the frame is the first word received since the previous `in_done`.
- R2: `out_snd` is frame bits [13:8], so the top two sender bits are ignored. `out_sub_mask` is frame bits [12:8]: one bit per attached sub-device, with values 0x01, 0x02, 0x04, 0x08 and 0x10.
- R3: `out_err_crc` is 1 exactly when the XOR of all bytes of all words received in the packet differs from `in_crc`.
- R4: `out_err_len` is 1 when `in_bits` differs from 32 × (1 + `out_len`) + 8. It is also 1 when the number of words received differs from 1 + `out_len`.
- R5: For the fixed-size replies, the payload length must match the command, or `out_err_len` is 1. The required lengths are: 0x05 needs 28, 0x06 needs 48, 0x07 and 0xFB–0xFE need 0, and 0x08 needs 2 to 255.
- R6: `out_err_cmd` is 1 exactly when the command is not one of 0x05, 0x06, 0x07, 0x08, 0xFB, 0xFC, 0xFD or 0xFE. An unknown command gets no command-specific length rule.
- R7: `out_ok` is 1 exactly when none of `out_err_crc`, `out_err_len` or `out_err_cmd` is set.
- R8: After reset, `out_vld`, `out_ok` and all error flags read 0.
- R9: A packet that ends with no words received reports `out_err_len` = 1 and all decoded fields as 0.
- R10: The checksum and word count restart after every `in_done`. An earlier packet, good or bad, has no effect on the next verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word_vld | input | 1 | A received word is present on `in_word` |
| in_word | input | 32 | Received word, little-endian byte order |
| in_done | input | 1 | Packet finished; `in_bits` and `in_crc` are valid |
| in_bits | input | BIT_W | Number of bits sampled in the packet |
| in_crc | input | 8 | Trailing checksum byte of the packet |
| out_vld | output | 1 | One-cycle verdict strobe |
| out_ok | output | 1 | Packet passed every check |
| out_err_crc | output | 1 | Checksum mismatch |
| out_err_len | output | 1 | Length or bit count inconsistent |
| out_err_cmd | output | 1 | Command code not a known reply |
| out_cmd | output | 8 | Command field |
| out_rcp | output | 8 | Recipient address field |
| out_snd | output | 6 | Sender address with player bits dropped |
| out_sub_mask | output | 5 | Attached sub-device map |
| out_len | output | 8 | Payload word count field |

## Verification
The assertions take two things for granted about the inputs. First, `in_done` never coincides with `in_word_vld`, so the final word is always folded in before the verdict. Second, the receiver's bit count fits in `in_bits`. The bench keeps within both. It drives each word and the done strobe on separate falling clock edges. Its bit counts, including deliberately wrong ones, stay far below 2^16. It sweeps every command code, every data-transfer length and every sender value, each arithmetic-checked against the length and checksum rules.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] rcp;
    logic [7:0] snd;
    logic [7:0] len;
  } frame_t;

  localparam logic [7:0] CMD_INFO     = 8'h05;
  localparam logic [7:0] CMD_INFO_EXT = 8'h06;
  localparam logic [7:0] CMD_ACK      = 8'h07;
  localparam logic [7:0] CMD_DATA     = 8'h08;

  localparam logic [7:0] LEN_INFO     = 8'd28;
  localparam logic [7:0] LEN_INFO_EXT = 8'd48;
  localparam logic [7:0] LEN_DATA_MIN = 8'd2;

  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      CMD_INFO, CMD_INFO_EXT, CMD_ACK, CMD_DATA,
      8'hFB, 8'hFC, 8'hFD, 8'hFE: cmd_known = 1'b1;
      default:                    cmd_known = 1'b0;
    endcase
  endfunction

  function automatic logic len_fits(input logic [7:0] c, input logic [7:0] l);
    case (c)
      CMD_INFO:                        len_fits = (l == LEN_INFO);
      CMD_INFO_EXT:                    len_fits = (l == LEN_INFO_EXT);
      CMD_DATA:                        len_fits = (l >= LEN_DATA_MIN);
      CMD_ACK, 8'hFB, 8'hFC, 8'hFD, 8'hFE: len_fits = (l == 8'd0);
      default:                         len_fits = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rxv_xor_acc.sv
module rxv_xor_acc #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  word_vld,
  input  logic [8*NBYTES-1:0]   word,
  output logic [7:0]            acc
);

  logic [7:0] part [NBYTES+1];

  assign part[0] = 8'h00;

  for (genvar g = 0; g < NBYTES; g++) begin : g_fold
    assign part[g+1] = part[g] ^ word[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  acc <= 8'h00;
    else if (word_vld) acc <= acc ^ part[NBYTES];
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == 8'h00)); // R10

endmodule

// File: rtl/rxv_frame_cap.sv
module rxv_frame_cap
  import rxv_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             word_vld,
  input  logic [31:0]      word,
  output frame_t           frm,
  output logic [CNT_W-1:0] wcnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      frm  <= '0;
      wcnt <= '0;
    end else if (word_vld) begin
      if (wcnt == '0) frm <= frame_t'(word);
      if (wcnt != CNT_MAX) wcnt <= wcnt + 1'b1;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    clear |=> (wcnt == '0)); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear && word_vld && wcnt != CNT_MAX) |=> (wcnt == $past(wcnt) + 1'b1)); // R4

endmodule

// File: rtl/rxv_rules.sv
module rxv_rules
  import rxv_pkg::*;
#(
  parameter int BIT_W = 16,
  parameter int CNT_W = 9
) (
  input  logic [7:0]       cmd,
  input  logic [7:0]       len,
  input  logic [CNT_W-1:0] wcnt,
  input  logic [BIT_W-1:0] bits,
  input  logic [7:0]       acc,
  input  logic [7:0]       tail,
  output logic             err_crc,
  output logic             err_len,
  output logic             err_cmd
);

  logic [31:0] exp_bits;
  logic        bits_ok;
  logic        count_ok;
  logic        known;

  always_comb begin
    exp_bits = (32'(len) << 5) + 32'd40;
    bits_ok  = (32'(bits) == exp_bits);
    count_ok = (wcnt == CNT_W'(len) + CNT_W'(1));
    known    = cmd_known(cmd);
    err_crc  = (acc != tail);
    err_cmd  = !known;
    err_len  = (wcnt == '0) || !bits_ok || !count_ok || (known && !len_fits(cmd, len));
  end

endmodule

// File: rtl/resp_pkt_validator.sv
module resp_pkt_validator
  import rxv_pkg::*;
#(
  parameter int BIT_W     = 16,
  parameter int MAX_WORDS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_word_vld,
  input  logic [31:0]      in_word,
  input  logic             in_done,
  input  logic [BIT_W-1:0] in_bits,
  input  logic [7:0]       in_crc,
  output logic             out_vld,
  output logic             out_ok,
  output logic             out_err_crc,
  output logic             out_err_len,
  output logic             out_err_cmd,
  output logic [7:0]       out_cmd,
  output logic [7:0]       out_rcp,
  output logic [5:0]       out_snd,
  output logic [4:0]       out_sub_mask,
  output logic [7:0]       out_len
);

  localparam int CNT_W = $clog2(MAX_WORDS + 2);

  frame_t           frm;
  logic [CNT_W-1:0] wcnt;
  logic [7:0]       acc;
  logic             e_crc, e_len, e_cmd;

  rxv_xor_acc #(.NBYTES(4)) u_acc (
    .clk(clk), .rst(rst), .clear(in_done),
    .word_vld(in_word_vld), .word(in_word), .acc(acc)
  );

  rxv_frame_cap #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .clear(in_done),
    .word_vld(in_word_vld), .word(in_word), .frm(frm), .wcnt(wcnt)
  );

  rxv_rules #(.BIT_W(BIT_W), .CNT_W(CNT_W)) u_rules (
    .cmd(frm.cmd), .len(frm.len), .wcnt(wcnt), .bits(in_bits),
    .acc(acc), .tail(in_crc),
    .err_crc(e_crc), .err_len(e_len), .err_cmd(e_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld      <= 1'b0;
      out_ok       <= 1'b0;
      out_err_crc  <= 1'b0;
      out_err_len  <= 1'b0;
      out_err_cmd  <= 1'b0;
      out_cmd      <= '0;
      out_rcp      <= '0;
      out_snd      <= '0;
      out_sub_mask <= '0;
      out_len      <= '0;
    end else begin
      out_vld <= in_done;
      if (in_done) begin
        out_ok       <= !(e_crc || e_len || e_cmd);
        out_err_crc  <= e_crc;
        out_err_len  <= e_len;
        out_err_cmd  <= e_cmd;
        out_cmd      <= frm.cmd;
        out_rcp      <= frm.rcp;
        out_snd      <= frm.snd[5:0];
        out_sub_mask <= frm.snd[4:0];
        out_len      <= frm.len;
      end
    end
  end

  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (rst)
    !(in_done && in_word_vld)); // R4

  AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_done |=> out_vld); // R1

  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !$past(in_done)) |-> 1'b0); // R1

  AST_EMPTY_LEN: assert property (@(posedge clk) disable iff (rst)
    (in_done && wcnt == '0) |=> (out_err_len && !out_ok)); // R9

  AST_ACK_LEN: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_cmd == CMD_ACK && out_len != 8'd0) |-> out_err_len); // R5

  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_ok |-> !(out_err_crc || out_err_len || out_err_cmd)); // R7

  AST_SUB_IN_SND: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_sub_mask == out_snd[4:0])); // R2

endmodule

// File: tb/resp_pkt_validator_test.sv
module resp_pkt_validator_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_word_vld;
  logic [31:0] in_word;
  logic        in_done;
  logic [15:0] in_bits;
  logic [7:0]  in_crc;
  logic        out_vld, out_ok, out_err_crc, out_err_len, out_err_cmd;
  logic [7:0]  out_cmd, out_rcp, out_len;
  logic [5:0]  out_snd;
  logic [4:0]  out_sub_mask;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  resp_pkt_validator uut (
    .clk(clk), .rst(rst), .in_word_vld(in_word_vld), .in_word(in_word),
    .in_done(in_done), .in_bits(in_bits), .in_crc(in_crc),
    .out_vld(out_vld), .out_ok(out_ok), .out_err_crc(out_err_crc),
    .out_err_len(out_err_len), .out_err_cmd(out_err_cmd),
    .out_cmd(out_cmd), .out_rcp(out_rcp), .out_snd(out_snd),
    .out_sub_mask(out_sub_mask), .out_len(out_len)
  );

  function automatic bit known_cmd(input logic [7:0] c);
    return (c >= 8'h05 && c <= 8'h08) || (c >= 8'hFB && c <= 8'hFE);
  endfunction

  function automatic bit len_rule(input logic [7:0] c, input logic [7:0] l);
    if (c == 8'h05) return l == 28;
    if (c == 8'h06) return l == 48;
    if (c == 8'h08) return l >= 2;
    if (known_cmd(c)) return l == 0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] natural_len(input logic [7:0] c);
    if (c == 8'h05) return 8'd28;
    if (c == 8'h06) return 8'd48;
    if (c == 8'h08) return 8'd2;
    if (known_cmd(c)) return 8'd0;
    return 8'd1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input string tag, input logic [7:0] cmd, input logic [7:0] rcp,
                          input logic [7:0] snd, input logic [7:0] len, input int nwords,
                          input int bit_delta, input logic [7:0] flip);
    logic [31:0] w;
    logic [7:0]  x;
    bit e_crc, e_len, e_cmd;
    logic [7:0] c, r, s, l;
    x = 8'h00;
    for (int i = 0; i < nwords; i++) begin
      if (i == 0) w = {cmd, rcp, snd, len};
      else        w = (32'(i) * 32'h9E37_79B9) ^ {cmd, 8'(i), len, 8'h3C};
      x = x ^ w[7:0] ^ w[15:8] ^ w[23:16] ^ w[31:24];
      @(negedge clk);
      in_word_vld = 1'b1;
      in_word = w;
    end
    @(negedge clk);
    in_word_vld = 1'b0;
    in_done = 1'b1;
    in_bits = 16'(32 * (1 + int'(len)) + 8 + bit_delta);
    in_crc = x ^ flip;
    @(negedge clk);
    in_done = 1'b0;
    if (nwords == 0) begin c = 0; r = 0; s = 0; l = 0; end
    else begin c = cmd; r = rcp; s = snd; l = len; end
    e_crc = (flip != 8'h00);
    e_cmd = !known_cmd(c);
    e_len = (nwords == 0) || (bit_delta != 0) || (nwords != 1 + int'(l)) ||
            (known_cmd(c) && !len_rule(c, l));
    check(tag,
          {25'd0, out_vld, out_ok, out_err_crc, out_err_len, out_err_cmd,
           out_cmd, out_rcp, out_snd, out_sub_mask, out_len},
          {25'd0, 1'b1, !(e_crc || e_len || e_cmd), e_crc, e_len, e_cmd,
           c, r, s[5:0], s[4:0], l});
  endtask

  initial begin
    rst = 1'b1;
    in_word_vld = 1'b0;
    in_word = '0;
    in_done = 1'b0;
    in_bits = '0;
    in_crc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8 reset", {59'd0, out_vld, out_ok, out_err_crc, out_err_len, out_err_cmd}, 64'd0);

    // R6/R7: every command code at its natural length, otherwise clean
    for (int c = 0; c < 256; c++)
      send_pkt("R6 cmd sweep", 8'(c), 8'(c) ^ 8'h5A, 8'h20, natural_len(8'(c)),
               1 + int'(natural_len(8'(c))), 0, 8'h00);

    // R5: every command one word longer than natural
    for (int c = 0; c < 256; c++)
      send_pkt("R5 cmd long", 8'(c), 8'h00, 8'h21, natural_len(8'(c)) + 8'd1,
               2 + int'(natural_len(8'(c))), 0, 8'h00);

    // R5: data-transfer length sweep
    for (int l = 0; l < 256; l++)
      send_pkt("R5 data len", 8'h08, 8'h00, 8'h20, 8'(l), 1 + l, 0, 8'h00);

    // R2: every sender value
    for (int s = 0; s < 256; s++)
      send_pkt("R2 sender", 8'h07, 8'h00, 8'(s), 8'd0, 1, 0, 8'h00);

    // R3: single-bit checksum corruption
    for (int b = 0; b < 8; b++)
      send_pkt("R3 crc flip", 8'h05, 8'h00, 8'h20, 8'd28, 29, 0, 8'(1 << b));
    send_pkt("R3 crc good", 8'h05, 8'h00, 8'h20, 8'd28, 29, 0, 8'h00);

    // R4: bit count and word count mismatches
    send_pkt("R4 bits -8", 8'h08, 8'h00, 8'h20, 8'd3, 4, -8, 8'h00);
    send_pkt("R4 bits -1", 8'h08, 8'h00, 8'h20, 8'd3, 4, -1, 8'h00);
    send_pkt("R4 bits +1", 8'h08, 8'h00, 8'h20, 8'd3, 4, 1, 8'h00);
    send_pkt("R4 bits +32", 8'h08, 8'h00, 8'h20, 8'd3, 4, 32, 8'h00);
    send_pkt("R4 words short", 8'h08, 8'h00, 8'h20, 8'd3, 3, 0, 8'h00);
    send_pkt("R4 words long", 8'h08, 8'h00, 8'h20, 8'd3, 5, 0, 8'h00);

    // R9: empty packet
    send_pkt("R9 empty", 8'h00, 8'h00, 8'h00, 8'd0, 0, 0, 8'h00);

    // R10: bad packet followed by good one
    send_pkt("R10 bad first", 8'hFC, 8'h00, 8'h3F, 8'd0, 1, 0, 8'h81);
    send_pkt("R10 good after", 8'hFC, 8'h00, 8'h3F, 8'd0, 1, 0, 8'h00);

    // R1: verdict strobe lasts one cycle
    @(negedge clk);
    check("R1 pulse", {63'd0, out_vld}, 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule